// File: doc/BRIEF.md
# Glitch-Tolerant Cycle Timer Sampler

This block takes a snapshot of a free-running cycle timer whose register reads are sometimes corrupt. The timer word holds three fields in mixed radix: a 12-bit tick offset in bits [11:0] that counts 0..3071, a 13-bit cycle count in bits [24:12] that counts 0..7999, and a 7-bit seconds count in bits [31:25]. A pulse on the start input begins one snapshot. The block fetches timer words over a single-outstanding request/valid handshake and reports the accepted word with a one-cycle done pulse.

With the checking mode off, the block makes one read and returns that word. With it on, the block keeps the three newest words in a window. It turns each word into a linear tick count and accepts the newest word only when the two successive tick differences are both positive and neither is at least twice the other. A bounded number of retries caps the run. If the last window still fails, the newest word is returned anyway and a flag reports that the retries ran out.

Top module: `cyc_snap_sampler`

## Requirements
- R1: After reset, rd_req_o and done_o are low, result_o is zero and exhausted_o is low.
- R2: When quirk_i is low at the accepted start, exactly one read is made. result_o takes that read's data, exhausted_o is low, and done_o is high in the cycle after the edge that accepts the data.
- R3: When quirk_i is high at the accepted start, two reads are made before any check. Each later read shifts a three-word window (oldest dropped, newest appended) and is followed by one check. The reported word is always the newest read.
- R4: Each word converts to ticks as offset[11:0] + 3072*count[24:12] + 24576000*seconds[31:25], taken modulo 2^32, before any comparison. Words that cross a cycle or second boundary compare by their true tick distance.
- R5: A window is rejected when either successive tick difference, read as a signed 32-bit value, is zero or negative.
- R6: A window is rejected when either difference, divided by the other with integer division, gives 2 or more. A quotient of 1 (for example 199 over 100) is accepted.
- R7: At most 20 retries follow the first check, so at most 23 reads are made. When the 21st check fails, done_o rises together with exhausted_o high and result_o holds the newest word. exhausted_o is low after any accepted window.
- R8: rd_req_o is a one-cycle pulse, and no new request is issued until rd_valid_i has returned the previous one. An rd_valid_i with no request outstanding changes nothing.
- R9: start_i is ignored while a snapshot is in progress. quirk_i is sampled only when a start is accepted.
- R10: done_o is high for exactly one cycle per snapshot. result_o and exhausted_o change only on entry to that cycle and hold until the next completion. In checking mode done_o is high two cycles after the edge that accepts the last data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin one snapshot (accepted when idle) |
| quirk_i | input | 1 | Enable the three-word consistency check |
| rd_req_o | output | 1 | One-cycle request for a timer word |
| rd_valid_i | input | 1 | Timer word present on rd_data_i |
| rd_data_i | input | 32 | Timer word: seconds, cycle count, offset |
| result_o | output | 32 | Accepted timer word |
| done_o | output | 1 | One-cycle completion pulse |
| exhausted_o | output | 1 | Retry limit reached without a consistent window |

## Verification
The first request is due in the cycle after the edge that accepts start. Every later request is due one cycle after the edge that takes data, when that data does not end the run. done_o is due one cycle after the final data edge when checking is off, and two cycles after it when checking is on, because of the evaluation cycle. The bench's reference model counts served reads against the read count it computes from the sample list and sets a countdown on the negative edge where it drives the last word. It then compares done_o on every falling edge with that countdown and flags any request beyond the computed count. result_o, exhausted_o and the read total are compared a few idle cycles after the pulse, so that a late extra request would also be seen.

// File: rtl/cyc_snap_pkg.sv
package cyc_snap_pkg;
   typedef enum logic [2:0] {
      SNAP_IDLE,
      SNAP_REQ,
      SNAP_WAIT,
      SNAP_EVAL,
      SNAP_FIN
   } snap_state_e;
endpackage

// File: rtl/cyc_snap_ticks.sv
// Mixed-radix timer word to linear tick count (modulo 2^TICK_W).
module cyc_snap_ticks #(
   parameter int OFF_W         = 12,
   parameter int CNT_W         = 13,
   parameter int SEC_W         = 7,
   parameter int TICKS_PER_CYC = 3072,
   parameter int CYC_PER_SEC   = 8000,
   parameter int TICK_W        = 32
) (
   input  logic [OFF_W+CNT_W+SEC_W-1:0] word_i,
   output logic [TICK_W-1:0]            ticks_o
);
   localparam int TS_W      = OFF_W + CNT_W + SEC_W;
   localparam int SEC_TICKS = TICKS_PER_CYC * CYC_PER_SEC;

   logic [OFF_W-1:0] off;
   logic [CNT_W-1:0] cnt;
   logic [SEC_W-1:0] sec;

   assign off = word_i[OFF_W-1:0];
   assign cnt = word_i[OFF_W+CNT_W-1:OFF_W];
   assign sec = word_i[TS_W-1:OFF_W+CNT_W];

   assign ticks_o = TICK_W'(off)
                  + TICK_W'(cnt) * TICK_W'(TICKS_PER_CYC)
                  + TICK_W'(sec) * TICK_W'(SEC_TICKS);
endmodule

// File: rtl/cyc_snap_judge.sv
// Accepts a window of three tick counts when both steps are positive
// and neither step reaches twice the other.
module cyc_snap_judge #(
   parameter int TICK_W = 32
) (
   input  logic [TICK_W-1:0] old_i,
   input  logic [TICK_W-1:0] mid_i,
   input  logic [TICK_W-1:0] new_i,
   output logic              ok_o
);
   logic signed [TICK_W-1:0] d_a;
   logic signed [TICK_W-1:0] d_b;
   logic                     pos_a, pos_b;
   logic                     a_big, b_big;

   assign d_a   = signed'(mid_i - old_i);
   assign d_b   = signed'(new_i - mid_i);
   assign pos_a = (d_a > 0);
   assign pos_b = (d_b > 0);
   // For positive steps, a/b >= 2 exactly when a >= 2*b.
   assign a_big = ({1'b0, d_a} >= {d_b, 1'b0});
   assign b_big = ({1'b0, d_b} >= {d_a, 1'b0});
   assign ok_o  = pos_a && pos_b && !a_big && !b_big;
endmodule

// File: rtl/cyc_snap_sampler.sv
module cyc_snap_sampler
   import cyc_snap_pkg::*;
#(
   parameter int OFF_W         = 12,
   parameter int CNT_W         = 13,
   parameter int SEC_W         = 7,
   parameter int TICKS_PER_CYC = 3072,
   parameter int CYC_PER_SEC   = 8000,
   parameter int MAX_RETRY     = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          quirk_i,
   output logic                          rd_req_o,
   input  logic                          rd_valid_i,
   input  logic [OFF_W+CNT_W+SEC_W-1:0]  rd_data_i,
   output logic [OFF_W+CNT_W+SEC_W-1:0]  result_o,
   output logic                          done_o,
   output logic                          exhausted_o
);
   localparam int TS_W    = OFF_W + CNT_W + SEC_W;
   localparam int TICK_W  = 32;
   localparam int WIN     = 3;
   localparam int PRIME   = WIN - 1;
   localparam int PRIME_W = $clog2(WIN);
   localparam int RETRY_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

   generate
      if (TS_W != 32) begin : g_chk_width
         $error("timer word must be 32 bits wide");
      end
      if (TICKS_PER_CYC > (1 << OFF_W)) begin : g_chk_off
         $error("offset field too narrow for ticks per cycle");
      end
      if (CYC_PER_SEC > (1 << CNT_W)) begin : g_chk_cnt
         $error("count field too narrow for cycles per second");
      end
      if (MAX_RETRY < 0) begin : g_chk_retry
         $error("retry limit must not be negative");
      end
   endgenerate

   snap_state_e         state_q;
   logic                quirk_q;
   logic [PRIME_W-1:0]  prime_q;
   logic [RETRY_W-1:0]  retry_q;
   logic [TS_W-1:0]     raw_q  [WIN];
   logic [TICK_W-1:0]   tick_q [WIN];
   logic [TICK_W-1:0]   new_ticks;
   logic                win_ok;
   logic                take;

   cyc_snap_ticks #(
      .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W),
      .TICKS_PER_CYC(TICKS_PER_CYC), .CYC_PER_SEC(CYC_PER_SEC),
      .TICK_W(TICK_W)
   ) u_ticks (
      .word_i (rd_data_i),
      .ticks_o(new_ticks)
   );

   cyc_snap_judge #(.TICK_W(TICK_W)) u_judge (
      .old_i(tick_q[0]),
      .mid_i(tick_q[1]),
      .new_i(tick_q[WIN-1]),
      .ok_o (win_ok)
   );

   assign take     = (state_q == SNAP_WAIT) && rd_valid_i;
   assign rd_req_o = (state_q == SNAP_REQ);
   assign done_o   = (state_q == SNAP_FIN);

   // Sliding window: index 0 oldest, WIN-1 newest.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WIN; i++) begin
            raw_q[i]  <= '0;
            tick_q[i] <= '0;
         end
      end else if (take) begin
         for (int i = 0; i < WIN - 1; i++) begin
            raw_q[i]  <= raw_q[i+1];
            tick_q[i] <= tick_q[i+1];
         end
         raw_q[WIN-1]  <= rd_data_i;
         tick_q[WIN-1] <= new_ticks;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SNAP_IDLE;
         quirk_q     <= 1'b0;
         prime_q     <= '0;
         retry_q     <= '0;
         result_o    <= '0;
         exhausted_o <= 1'b0;
      end else begin
         case (state_q)
            SNAP_IDLE: begin
               if (start_i) begin
                  state_q <= SNAP_REQ;
                  quirk_q <= quirk_i;
                  prime_q <= '0;
                  retry_q <= '0;
               end
            end
            SNAP_REQ: state_q <= SNAP_WAIT;
            SNAP_WAIT: begin
               if (rd_valid_i) begin
                  if (!quirk_q) begin
                     result_o    <= rd_data_i;
                     exhausted_o <= 1'b0;
                     state_q     <= SNAP_FIN;
                  end else if (prime_q != PRIME_W'(PRIME)) begin
                     prime_q <= prime_q + 1'b1;
                     state_q <= SNAP_REQ;
                  end else begin
                     state_q <= SNAP_EVAL;
                  end
               end
            end
            SNAP_EVAL: begin
               if (win_ok) begin
                  result_o    <= raw_q[WIN-1];
                  exhausted_o <= 1'b0;
                  state_q     <= SNAP_FIN;
               end else if (retry_q == RETRY_W'(MAX_RETRY)) begin
                  result_o    <= raw_q[WIN-1];
                  exhausted_o <= 1'b1;
                  state_q     <= SNAP_FIN;
               end else begin
                  retry_q <= retry_q + 1'b1;
                  state_q <= SNAP_REQ;
               end
            end
            SNAP_FIN: state_q <= SNAP_IDLE;
            default:  state_q <= SNAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cyc_snap_chk.sv
module cyc_snap_chk #(
   parameter int TS_W      = 32,
   parameter int MAX_RETRY = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rd_req_o,
   input logic            rd_valid_i,
   input logic            done_o,
   input logic            exhausted_o,
   input logic [TS_W-1:0] result_o
);
   logic        outst_q;
   logic [15:0] reads_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q <= 1'b0;
         reads_q <= '0;
      end else begin
         if (rd_req_o)        outst_q <= 1'b1;
         else if (rd_valid_i) outst_q <= 1'b0;
         if (done_o)          reads_q <= '0;
         else if (rd_req_o)   reads_q <= reads_q + 16'd1;
      end
   end

   // R8: single request outstanding, request is a pulse
   p_single_outst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> !outst_q);
   p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);
   // R10: done is a one-cycle pulse; outputs hold between completions
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(exhausted_o)));
   // R7: exhausted only rises with done, after the full read budget
   p_exh_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exhausted_o) |-> done_o);
   p_exh_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && exhausted_o) |-> (32'(reads_q) == MAX_RETRY + 3));
   // R3: every snapshot makes at least one and at most the budgeted reads
   p_read_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (reads_q >= 16'd1 && 32'(reads_q) <= MAX_RETRY + 3));
endmodule

bind cyc_snap_sampler cyc_snap_chk #(
   .TS_W(OFF_W + CNT_W + SEC_W),
   .MAX_RETRY(MAX_RETRY)
) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .rd_req_o(rd_req_o),
   .rd_valid_i(rd_valid_i),
   .done_o(done_o),
   .exhausted_o(exhausted_o),
   .result_o(result_o)
);

// File: tb/cyc_snap_sampler_test.sv
module cyc_snap_sampler_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        quirk_i = 1'b0;
   logic        rd_valid_i = 1'b0;
   logic [31:0] rd_data_i = '0;
   logic        rd_req_o;
   logic [31:0] result_o;
   logic        done_o;
   logic        exhausted_o;

   always #5 clk = ~clk;

   cyc_snap_sampler uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .quirk_i(quirk_i),
      .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
      .result_o(result_o), .done_o(done_o), .exhausted_o(exhausted_o)
   );

   int total = 0;
   int bad = 0;
   bit [31:0] feed[$];
   bit [31:0] stim[$];
   int exp_k = 0, served = 0, reqs = 0, done_in = -1, lat = 1, wait_cnt = 0;
   bit m_quirk = 0, seen_done = 0, mon_on = 0;

   task automatic chk(string tag, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic longint to_ticks(bit [31:0] w);
      return longint'(w[11:0]) + 3072 * longint'(w[24:12]) + 24576000 * longint'(w[31:25]);
   endfunction

   function automatic bit [31:0] enc(longint t);
      longint sec = t / 24576000;
      longint rem = t % 24576000;
      return 32'((sec << 25) | ((rem / 3072) << 12) | (rem % 3072));
   endfunction

   function automatic int step(bit [31:0] a, bit [31:0] b);
      bit [31:0] u = 32'(to_ticks(b)) - 32'(to_ticks(a));
      return signed'(u);
   endfunction

   // Behavioural reference of the snapshot rule (R2..R7)
   function automatic void ref_model(input bit [31:0] s[$], input bit q,
                                     output bit [31:0] res, output bit ex, output int k);
      bit [31:0] c0, c1, c2;
      int idx, tries, da, db;
      bit reject;
      ex = 0;
      if (!q) begin res = s[0]; k = 1; return; end
      c1 = s[0]; c2 = s[1]; idx = 2; tries = 0;
      forever begin
         if (idx >= s.size()) begin ex = 1; break; end
         c0 = c1; c1 = c2; c2 = s[idx]; idx++;
         da = step(c0, c1); db = step(c1, c2);
         reject = (da <= 0) || (db <= 0) || (da / db >= 2) || (db / da >= 2);
         if (!reject) break;
         if (tries >= 20) begin ex = 1; break; end
         tries++;
      end
      res = c2; k = idx;
   endfunction

   // Per-clock reference comparison and read responder
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R10", "done pulse timing", done_o, done_in == 0);
         if (done_o) seen_done = 1;
         if (done_in >= 0) done_in--;
         if (rd_valid_i) rd_valid_i = 1'b0;
         if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
               chk("R8", "feed not empty", feed.size() > 0, 1);
               rd_valid_i = 1'b1;
               rd_data_i = (feed.size() > 0) ? feed.pop_front() : 32'h0;
               served++;
               if (served == exp_k) done_in = m_quirk ? 1 : 0;
            end
         end
         if (rd_req_o) begin
            reqs++;
            chk("R8", "request within read budget", reqs <= exp_k, 1);
            chk("R8", "no request while outstanding", wait_cnt, 0);
            wait_cnt = lat;
         end
      end
   end

   task automatic run_case(string tag, bit q, int l, bit poke);
      bit [31:0] er;
      bit ee;
      int ek;
      ref_model(stim, q, er, ee, ek);
      feed = stim; exp_k = ek; served = 0; reqs = 0; lat = l;
      seen_done = 0; m_quirk = q;
      @(negedge clk); #1 quirk_i = q; start_i = 1'b1;
      @(negedge clk); #1 start_i = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         #1 start_i = 1'b1; quirk_i = ~q;     // R9: ignored while busy
         @(negedge clk); #1 start_i = 1'b0;
      end
      for (int n = 0; n < 3000 && !seen_done; n++) @(negedge clk);
      repeat (4) @(negedge clk);
      #1 quirk_i = 1'b0;
      chk(tag, "completed", seen_done, 1);
      chk(tag, "result", result_o, er);
      chk(tag, "exhausted", exhausted_o, ee);
      chk(tag, "read count", reqs, ek);
      chk(tag, "feed consumed", feed.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      bit [31:0] keep;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rd_req after reset", rd_req_o, 0);
      chk("R1", "done after reset", done_o, 0);
      chk("R1", "result after reset", result_o, 0);
      chk("R1", "exhausted after reset", exhausted_o, 0);
      mon_on = 1;

      // R2: single read, checking off
      stim.delete(); stim.push_back(enc(123456789));
      run_case("R2", 0, 2, 0);

      // R3: clean three reads accepted at once
      stim.delete();
      stim.push_back(enc(1000)); stim.push_back(enc(1100)); stim.push_back(enc(1200));
      run_case("R3", 1, 1, 0);

      // R5: zero step (duplicate word) rejected, next window accepted
      stim.delete();
      stim.push_back(enc(5000)); stim.push_back(enc(5000));
      stim.push_back(enc(5100)); stim.push_back(enc(5200));
      run_case("R5", 1, 3, 0);

      // R5/R6: zero glitch gives a negative step, then a step ratio far above 2
      stim.delete();
      stim.push_back(enc(10000)); stim.push_back(32'h0); stim.push_back(enc(10200));
      stim.push_back(enc(10300)); stim.push_back(enc(10400));
      run_case("R6", 1, 2, 0);

      // R6: quotient exactly 2 rejected, quotient 1 (199/100) accepted
      stim.delete();
      stim.push_back(enc(20000)); stim.push_back(enc(20200));
      stim.push_back(enc(20300)); stim.push_back(enc(20499));
      run_case("R6", 1, 1, 0);

      // R4: offset wraps into the cycle count, then count wraps into seconds
      stim.delete();
      stim.push_back(enc(3072*5 + 3000)); stim.push_back(enc(3072*5 + 3050));
      stim.push_back(enc(3072*5 + 3100));
      run_case("R4", 1, 1, 0);
      stim.delete();
      stim.push_back(enc(24576000*3 - 40)); stim.push_back(enc(24576000*3));
      stim.push_back(enc(24576000*3 + 40));
      run_case("R4", 1, 2, 0);

      // R7 + R9: decreasing words exhaust the retries; start/quirk poked mid-run
      stim.delete();
      for (int i = 0; i < 23; i++) stim.push_back(enc(900000 - 7*i));
      run_case("R7", 1, 1, 1);

      // R7: accepted run after an exhausted one clears the flag
      stim.delete();
      stim.push_back(enc(40000)); stim.push_back(enc(40300)); stim.push_back(enc(40600));
      run_case("R7", 1, 2, 0);

      // R8: stray valid while idle changes nothing
      keep = result_o;
      exp_k = 0; reqs = 0;
      @(negedge clk); #1 rd_valid_i = 1'b1; rd_data_i = 32'hDEAD_BEEF;
      repeat (4) @(negedge clk);
      chk("R8", "result after stray valid", result_o, keep);
      chk("R8", "no request after stray valid", reqs, 0);

      // R9: quirk_i sampled at start only (low at start, high afterwards)
      stim.delete(); stim.push_back(enc(777777));
      exp_k = 1; feed = stim; served = 0; reqs = 0; lat = 3; seen_done = 0; m_quirk = 0;
      @(negedge clk); #1 start_i = 1'b1;
      @(negedge clk); #1 start_i = 1'b0; quirk_i = 1'b1;
      repeat (10) @(negedge clk);
      #1 quirk_i = 1'b0;
      chk("R9", "single read despite late quirk", reqs, 1);
      chk("R9", "result", result_o, enc(777777));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule